// File: doc/BRIEF.md
# Dual-Lane Multiply-Accumulate Unit

This block holds two 16×16 multiply-accumulate lanes, each with its own 40-bit accumulator. One command word carries an operation code, a two-bit lane select and four 16-bit operands, two per lane. The selected lanes all perform that one operation in the same cycle. A lane that is not selected keeps its accumulator. Products can be taken as plain signed integers or as signed fractions. In fractional mode the product is doubled, and the single case that would overflow is forced to the largest positive value. Each accumulator sign-extends the 32-bit product into 40 bits, which gives eight guard bits. A 32-bit readout is provided per lane, either truncated or clamped to the signed 32-bit range.

The same two multipliers also produce the low 32 bits of a 32×32 product. For this the block takes unsigned 16-bit partial products over five steps and adds them. While this runs, the block reports busy and refuses every other command. At the end it pulses done for one cycle with the result.

Top module: `dual_mac`

## Requirements
- R1: After reset both accumulators are zero, and busy and done are low.
- R2: Opcode 2 (load product) with a lane selected (laneSel bit 0 = lane 0, bit 1 = lane 1) places the sign-extended signed product of that lane's operands in its accumulator at the next clock edge. An unselected lane keeps its value.
- R3: Opcode 3 adds and opcode 4 subtracts the lane product to or from the accumulator. One such command is accepted per cycle with no gaps. The 40-bit sum wraps modulo 2^40.
- R4: Opcode 1 clears the accumulator of each selected lane at the next edge. An unselected lane keeps its value.
- R5: With laneSel = 2'b11 both lanes carry out the same opcode in the same cycle, each lane on its own operand pair.
- R6: With fracMode high the product is shifted left by one bit. The operand pair 0x8000 × 0x8000 gives 0x7FFFFFFF, so the accumulator holds 40'h007FFFFFFF after a load.
- R7: With satRead low, rdN is bits 31:0 of accumulator N. With satRead high, rdN is the accumulator clamped to the range 0x80000000..0x7FFFFFFF.
- R8: Opcode 5 multiplies {opA1,opA0} by {opB1,opB0}. Busy is high for exactly five cycles starting with the cycle after acceptance. Done is then high for one cycle, and wideRes holds the low 32 bits of the product from that cycle until the next opcode 5 completes.
- R9: While busy is high, every command is ignored: both accumulators stay unchanged, and a further opcode 5 neither restarts nor lengthens the sequence.
- R10: Opcodes 0, 6 and 7 change nothing, and no opcode has any effect while cmdValid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | Command present this cycle |
| cmdOp | input | 3 | Operation code |
| laneSel | input | 2 | Lane select mask |
| fracMode | input | 1 | Fractional product format |
| satRead | input | 1 | Clamp the readouts to 32 bits |
| opA0 | input | 16 | Lane 0 operand A / low half of wide A |
| opB0 | input | 16 | Lane 0 operand B / low half of wide B |
| opA1 | input | 16 | Lane 1 operand A / high half of wide A |
| opB1 | input | 16 | Lane 1 operand B / high half of wide B |
| acc0 | output | 40 | Lane 0 accumulator |
| acc1 | output | 40 | Lane 1 accumulator |
| rd0 | output | 32 | Lane 0 32-bit readout |
| rd1 | output | 32 | Lane 1 32-bit readout |
| busy | output | 1 | Wide multiply in progress |
| done | output | 1 | Wide result valid pulse |
| wideRes | output | 32 | Wide multiply result |

## Verification
Every accumulator update appears on accN at the first edge after the command, so a wrong product, a wrong sign extension or a wrongly strobed lane is visible one cycle later. A wrong partial product or a wrong sequence step in the wide multiply does not show until done, six edges after acceptance, as a wrong wideRes. A wrong step count shows earlier, as a busy window of the wrong length. A leak of commands during busy shows at the very next edge as a change on acc0 or acc1.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int LANES = 2;
  localparam int SEQ_STEPS = 5;

  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_CLR   = 3'd1,
    OP_MUL   = 3'd2,
    OP_MAC   = 3'd3,
    OP_MSU   = 3'd4,
    OP_MUL32 = 3'd5
  } macOp_e;

  typedef struct packed {
    logic [LANES-1:0] clr;
    logic [LANES-1:0] load;
    logic [LANES-1:0] add;
    logic [LANES-1:0] sub;
    logic             start;
    logic             seqRun;
    logic [2:0]       step;
    logic             finish;
  } macCtl_t;
endpackage

// File: rtl/dmac_lane.sv
module dmac_lane #(
  parameter int OPW  = 16,
  parameter int ACCW = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [OPW-1:0]    a,
  input  logic [OPW-1:0]    b,
  input  logic              uns,
  input  logic              frac,
  input  logic              clr,
  input  logic              load,
  input  logic              add,
  input  logic              sub,
  output logic [ACCW-1:0]   acc,
  output logic [2*OPW-1:0]  rawProd
);
  localparam int PW    = 2 * OPW;
  localparam int GUARD = ACCW - PW;

  logic signed [OPW:0]    aExt, bExt;
  logic signed [PW+1:0]   full;
  logic [PW-1:0]          prodI, prodF, prodSel;
  logic                   minPair;
  logic [ACCW-1:0]        prodExt;

  assign aExt    = $signed({~uns & a[OPW-1], a});
  assign bExt    = $signed({~uns & b[OPW-1], b});
  assign full    = aExt * bExt;
  assign rawProd = full[PW-1:0];
  assign prodI   = full[PW-1:0];
  assign minPair = (a == {1'b1, {(OPW-1){1'b0}}}) && (b == {1'b1, {(OPW-1){1'b0}}});
  assign prodF   = minPair ? {1'b0, {(PW-1){1'b1}}} : {prodI[PW-2:0], 1'b0};
  assign prodSel = frac ? prodF : prodI;
  assign prodExt = {{GUARD{prodSel[PW-1]}}, prodSel};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     acc <= '0;
    else if (clr)  acc <= '0;
    else if (load) acc <= prodExt;
    else if (add)  acc <= acc + prodExt;
    else if (sub)  acc <= acc - prodExt;
  end
endmodule

// File: rtl/dmac_ctrl.sv
module dmac_ctrl
  import dmac_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [2:0]       cmdOp,
  input  logic [LANES-1:0] laneSel,
  output macCtl_t          ctl,
  output logic             busy,
  output logic             done
);
  localparam logic [2:0] LAST = 3'(SEQ_STEPS - 1);

  logic [2:0] stepQ;
  logic       accept;

  assign accept = cmdValid && !busy;

  always_comb begin
    ctl = '0;
    if (accept) begin
      case (macOp_e'(cmdOp))
        OP_CLR:   ctl.clr   = laneSel;
        OP_MUL:   ctl.load  = laneSel;
        OP_MAC:   ctl.add   = laneSel;
        OP_MSU:   ctl.sub   = laneSel;
        OP_MUL32: ctl.start = 1'b1;
        default:  ;
      endcase
    end
    ctl.seqRun = busy;
    ctl.step   = stepQ;
    ctl.finish = busy && (stepQ == LAST);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy  <= 1'b0;
      stepQ <= '0;
      done  <= 1'b0;
    end else begin
      done <= ctl.finish;
      if (ctl.start) begin
        busy  <= 1'b1;
        stepQ <= '0;
      end else if (busy) begin
        if (stepQ == LAST) begin
          busy  <= 1'b0;
          stepQ <= '0;
        end else begin
          stepQ <= stepQ + 3'd1;
        end
      end
    end
  end
endmodule

// File: rtl/dmac_dp.sv
module dmac_dp
  import dmac_pkg::*;
#(
  parameter int OPW  = 16,
  parameter int ACCW = 40
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  macCtl_t                     ctl,
  input  logic                        fracMode,
  input  logic                        satRead,
  input  logic [LANES-1:0][OPW-1:0]   opA,
  input  logic [LANES-1:0][OPW-1:0]   opB,
  output logic [LANES-1:0][ACCW-1:0]  acc,
  output logic [LANES-1:0][2*OPW-1:0] rd,
  output logic [2*OPW-1:0]            wideRes
);
  localparam int PW = 2 * OPW;

  logic [PW-1:0]                wA, wB, pp0, pp1, pp2, sumQ;
  logic [LANES-1:0][OPW-1:0]    laneA, laneB;
  logic [LANES-1:0][PW-1:0]     raw;
  logic                         laneUns, laneFrac;

  always_comb begin
    if (ctl.seqRun) begin
      laneA[0] = wA[OPW-1:0];
      laneB[0] = (ctl.step == 3'd0) ? wB[OPW-1:0] : wB[PW-1:OPW];
      laneA[1] = wA[PW-1:OPW];
      laneB[1] = wB[OPW-1:0];
      laneUns  = 1'b1;
      laneFrac = 1'b0;
    end else begin
      laneA    = opA;
      laneB    = opB;
      laneUns  = 1'b0;
      laneFrac = fracMode;
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : gLane
    dmac_lane #(.OPW(OPW), .ACCW(ACCW)) uLane (
      .clk(clk), .rstN(rstN), .a(laneA[i]), .b(laneB[i]),
      .uns(laneUns), .frac(laneFrac),
      .clr(ctl.clr[i]), .load(ctl.load[i]), .add(ctl.add[i]), .sub(ctl.sub[i]),
      .acc(acc[i]), .rawProd(raw[i])
    );

    logic inRange;
    assign inRange = (acc[i][ACCW-1:PW-1] == '0) || (acc[i][ACCW-1:PW-1] == '1);
    always_comb begin
      if (!satRead || inRange) rd[i] = acc[i][PW-1:0];
      else                     rd[i] = {acc[i][ACCW-1], {(PW-1){~acc[i][ACCW-1]}}};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wA <= '0; wB <= '0; pp0 <= '0; pp1 <= '0; pp2 <= '0;
      sumQ <= '0; wideRes <= '0;
    end else begin
      if (ctl.start) begin
        wA <= {opA[1], opA[0]};
        wB <= {opB[1], opB[0]};
      end
      if (ctl.seqRun) begin
        case (ctl.step)
          3'd0: begin pp0 <= raw[0]; pp1 <= raw[1]; end
          3'd1: pp2 <= raw[0];
          3'd2: sumQ <= pp0 + (pp1 << OPW);
          3'd3: sumQ <= sumQ + (pp2 << OPW);
          default: wideRes <= sumQ;
        endcase
      end
    end
  end
endmodule

// File: rtl/dual_mac.sv
module dual_mac
  import dmac_pkg::*;
#(
  parameter int OPW  = 16,
  parameter int ACCW = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [2:0]        cmdOp,
  input  logic [1:0]        laneSel,
  input  logic              fracMode,
  input  logic              satRead,
  input  logic [OPW-1:0]    opA0,
  input  logic [OPW-1:0]    opB0,
  input  logic [OPW-1:0]    opA1,
  input  logic [OPW-1:0]    opB1,
  output logic [ACCW-1:0]   acc0,
  output logic [ACCW-1:0]   acc1,
  output logic [2*OPW-1:0]  rd0,
  output logic [2*OPW-1:0]  rd1,
  output logic              busy,
  output logic              done,
  output logic [2*OPW-1:0]  wideRes
);
  macCtl_t                     ctl;
  logic [LANES-1:0][ACCW-1:0]  accV;
  logic [LANES-1:0][2*OPW-1:0] rdV;

  dmac_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .laneSel(laneSel), .ctl(ctl), .busy(busy), .done(done)
  );

  dmac_dp #(.OPW(OPW), .ACCW(ACCW)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .fracMode(fracMode), .satRead(satRead),
    .opA({opA1, opA0}), .opB({opB1, opB0}),
    .acc(accV), .rd(rdV), .wideRes(wideRes)
  );

  assign acc0 = accV[0];
  assign acc1 = accV[1];
  assign rd0  = rdV[0];
  assign rd1  = rdV[1];
endmodule

// File: rtl/dual_mac_chk.sv
module dual_mac_chk (
  input logic        clk,
  input logic        rstN,
  input logic        cmdValid,
  input logic [2:0]  cmdOp,
  input logic [1:0]  laneSel,
  input logic        fracMode,
  input logic        satRead,
  input logic [15:0] opA1,
  input logic [15:0] opB1,
  input logic [39:0] acc0,
  input logic [39:0] acc1,
  input logic [31:0] rd0,
  input logic        busy,
  input logic        done
);
  logic [3:0] busyCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     busyCnt <= '0;
    else if (busy) busyCnt <= busyCnt + 4'd1;
    else           busyCnt <= '0;
  end

  // R8
  busy_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> busyCnt < 4'd5);

  // R8
  done_after_five_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (busyCnt == 4'd5) && !busy);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9
  busy_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(acc0) && $stable(acc1));

  // R4
  clear_lane0_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !busy && cmdOp == 3'd1 && laneSel[0]) |=> acc0 == 40'd0);

  // R6
  frac_corner_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !busy && cmdOp == 3'd2 && laneSel[1] && fracMode &&
     opA1 == 16'h8000 && opB1 == 16'h8000) |=> acc1 == 40'h007FFFFFFF);

  // R7
  sat_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (satRead && acc0[39:31] != 9'h000 && acc0[39:31] != 9'h1FF) |->
      (rd0 == 32'h7FFFFFFF || rd0 == 32'h80000000));
endmodule

bind dual_mac dual_mac_chk i_dual_mac_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .laneSel(laneSel),
  .fracMode(fracMode), .satRead(satRead), .opA1(opA1), .opB1(opB1),
  .acc0(acc0), .acc1(acc1), .rd0(rd0), .busy(busy), .done(done)
);

// File: tb/test_dual_mac.sv
module test_dual_mac;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [2:0]  cmdOp = '0;
  logic [1:0]  laneSel = '0;
  logic        fracMode = 1'b0;
  logic        satRead = 1'b0;
  logic [15:0] opA0 = '0, opB0 = '0, opA1 = '0, opB1 = '0;
  logic [39:0] acc0, acc1;
  logic [31:0] rd0, rd1, wideRes;
  logic        busy, done;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_mac i_dual_mac (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .laneSel(laneSel),
    .fracMode(fracMode), .satRead(satRead), .opA0(opA0), .opB0(opB0),
    .opA1(opA1), .opB1(opB1), .acc0(acc0), .acc1(acc1), .rd0(rd0), .rd1(rd1),
    .busy(busy), .done(done), .wideRes(wideRes)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] v16(input int k);
    case (k % 8)
      0: return 16'h0000; 1: return 16'h0001; 2: return 16'hFFFF; 3: return 16'h7FFF;
      4: return 16'h8000; 5: return 16'h1234; 6: return 16'hEDCC; default: return 16'h4000;
    endcase
  endfunction

  function automatic logic [31:0] v32(input int k);
    case (k % 8)
      0: return 32'h00000000; 1: return 32'h00000001; 2: return 32'hFFFFFFFF;
      3: return 32'h7FFFFFFF; 4: return 32'h80000000; 5: return 32'h12345678;
      6: return 32'hDEADBEEF; default: return 32'h0001FFFF;
    endcase
  endfunction

  function automatic logic [39:0] mdl(input logic [15:0] a, input logic [15:0] b, input logic f);
    logic signed [63:0] p;
    p = 64'($signed(a)) * 64'($signed(b));
    if (f) begin
      if (a == 16'h8000 && b == 16'h8000) p = 64'sd2147483647;
      else p = p * 2;
    end
    return p[39:0];
  endfunction

  task automatic cmd(input logic [2:0] op, input logic [1:0] sel,
                     input logic [15:0] a0, input logic [15:0] b0,
                     input logic [15:0] a1, input logic [15:0] b1);
    cmdValid = 1'b1; cmdOp = op; laneSel = sel;
    opA0 = a0; opB0 = b0; opA1 = a1; opB1 = b1;
    @(posedge clk); @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [39:0] e0, e1;
    logic [63:0] wp;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 acc0", acc0, 0); chk("R1 acc1", acc1, 0);
    chk("R1 busy", busy, 0); chk("R1 done", done, 0);

    // R2 R5 R6: dual load over a sweep of operand pairs, integer then fractional
    for (int f = 0; f < 2; f++) begin
      fracMode = f[0];
      for (int i = 0; i < 8; i++) begin
        for (int j = 0; j < 8; j++) begin
          cmd(3'd2, 2'b11, v16(i), v16(j), v16(j), v16(i + 3));
          chk(f ? "R6 frac lane0" : "R5 dual lane0", acc0, mdl(v16(i), v16(j), f[0]));
          chk(f ? "R6 frac lane1" : "R5 dual lane1", acc1, mdl(v16(j), v16(i + 3), f[0]));
        end
      end
    end
    cmd(3'd2, 2'b10, 16'h0, 16'h0, 16'h8000, 16'h8000);
    chk("R6 corner", acc1, 40'h007FFFFFFF);
    fracMode = 1'b0;

    // R2 single lane, other keeps value
    cmd(3'd2, 2'b11, 16'h0003, 16'h0005, 16'h0007, 16'hFFFE);
    cmd(3'd2, 2'b01, 16'h0100, 16'hFF00, 16'h1111, 16'h1111);
    chk("R2 lane0 load", acc0, mdl(16'h0100, 16'hFF00, 1'b0));
    chk("R2 lane1 kept", acc1, mdl(16'h0007, 16'hFFFE, 1'b0));

    // R4 clear only lane 1
    cmd(3'd1, 2'b10, 16'h0, 16'h0, 16'h0, 16'h0);
    chk("R4 lane1 cleared", acc1, 0);
    chk("R4 lane0 kept", acc0, mdl(16'h0100, 16'hFF00, 1'b0));

    // R3 back-to-back add on lane 0, subtract on lane 1
    cmd(3'd1, 2'b11, 16'h0, 16'h0, 16'h0, 16'h0);
    e0 = '0; e1 = '0;
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        cmd(3'd3, 2'b01, v16(i), v16(j), 16'h0, 16'h0);
        e0 = e0 + mdl(v16(i), v16(j), 1'b0);
        cmd(3'd4, 2'b10, 16'h0, 16'h0, v16(j), v16(i + 5));
        e1 = e1 - mdl(v16(j), v16(i + 5), 1'b0);
      end
    end
    chk("R3 add sum", acc0, e0);
    chk("R3 sub sum", acc1, e1);
    e0 = '0;
    cmd(3'd1, 2'b01, 16'h0, 16'h0, 16'h0, 16'h0);
    for (int i = 0; i < 6; i++) begin
      cmd(3'd3, 2'b01, 16'h1234, 16'hEDCC, 16'h0, 16'h0);
      e0 = e0 + mdl(16'h1234, 16'hEDCC, 1'b0);
      chk("R3 one per cycle", acc0, e0);
    end

    // R3 wrap modulo 2^40 with fractional corner products
    fracMode = 1'b1;
    cmd(3'd1, 2'b01, 16'h0, 16'h0, 16'h0, 16'h0);
    e0 = '0;
    for (int i = 0; i < 257; i++) begin
      cmd(3'd3, 2'b01, 16'h8000, 16'h8000, 16'h0, 16'h0);
      e0 = e0 + 40'h007FFFFFFF;
    end
    chk("R3 wrap", acc0, e0);
    fracMode = 1'b0;

    // R7 readout: overflow both ways, truncated and clamped
    cmd(3'd1, 2'b11, 16'h0, 16'h0, 16'h0, 16'h0);
    for (int i = 0; i < 3; i++) begin
      cmd(3'd3, 2'b01, 16'h8000, 16'h8000, 16'h0, 16'h0);
      cmd(3'd4, 2'b10, 16'h0, 16'h0, 16'h8000, 16'h8000);
    end
    satRead = 1'b0; #1;
    chk("R7 raw pos", rd0, 32'hC0000000); chk("R7 raw neg", rd1, 32'h40000000);
    satRead = 1'b1; #1;
    chk("R7 clamp pos", rd0, 32'h7FFFFFFF); chk("R7 clamp neg", rd1, 32'h80000000);
    cmd(3'd2, 2'b11, 16'hFFFF, 16'h0005, 16'h0, 16'h0);
    chk("R7 in range", rd0, 32'hFFFFFFFB); chk("R7 zero", rd1, 0);
    satRead = 1'b0;

    // R10 inert opcodes and idle command port
    cmd(3'd2, 2'b11, 16'h0011, 16'h0022, 16'h0033, 16'h0044);
    e0 = acc0; e1 = acc1;
    cmd(3'd0, 2'b11, 16'h1, 16'h1, 16'h1, 16'h1);
    cmd(3'd6, 2'b11, 16'h1, 16'h1, 16'h1, 16'h1);
    cmd(3'd7, 2'b11, 16'h1, 16'h1, 16'h1, 16'h1);
    chk("R10 busy stays low", busy, 0);
    cmdOp = 3'd1; laneSel = 2'b11; @(posedge clk); @(negedge clk);
    chk("R10 acc0", acc0, e0); chk("R10 acc1", acc1, e1);

    // R8 R9 wide multiply sweep with commands thrown at it while busy
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        logic [31:0] a, b;
        a = v32(i); b = v32(j + 1);
        e0 = acc0; e1 = acc1;
        cmd(3'd5, 2'b00, a[15:0], b[15:0], a[31:16], b[31:16]);
        for (int k = 0; k < 5; k++) begin
          chk("R8 busy", busy, 1); chk("R8 no done", done, 0);
          if (k < 4) begin
            if (k == 2) cmd(3'd5, 2'b00, 16'h1, 16'h1, 16'h1, 16'h1);
            else        cmd(3'd1, 2'b11, 16'h0, 16'h0, 16'h0, 16'h0);
          end else begin
            @(posedge clk); @(negedge clk);
          end
        end
        chk("R9 acc0 kept", acc0, e0); chk("R9 acc1 kept", acc1, e1);
        wp = {32'h0, a} * {32'h0, b};
        chk("R8 done", done, 1); chk("R8 busy low", busy, 0);
        chk("R8 result", wideRes, {32'h0, wp[31:0]});
        @(posedge clk); @(negedge clk);
        chk("R9 no restart", busy, 0); chk("R8 done one cycle", done, 0);
        chk("R8 result held", wideRes, {32'h0, wp[31:0]});
      end
    end
    finish_run();
  end
endmodule